// File: doc/BRIEF.md
# Four-Phase Noise Envelope Channel

This block shapes one noise voice. A 4-bit amplitude is gated by a single noise bit supplied from outside: when the noise bit is high the output level is the current amplitude, otherwise it is zero. The amplitude follows a stepped envelope with four phases: attack, gap, sustain and done. A 14-bit down counter drives the envelope. Its two top bits hold the phase, and its lower twelve bits time the phase.

A start strobe loads the attack amplitude and the attack duration. After that, an update tick steps the envelope. When the attack expires, the level drops to zero for the gap. The sustain amplitude then follows for the sustain duration. After sustain, a release shrinks the level to three quarters of its value once every 4096 ticks until it reaches zero, and the envelope then stops. Each 8-bit duration goes into the middle of the counter, so one duration unit equals 16 ticks.

The durations and amplitudes are plain input ports, held steady by the surrounding logic. A new start restarts the attack at any time.

Top module: `noise_env_channel`

## Requirements
- R1: A start strobe sets the amplitude to the attack amplitude and loads the counter with phase 3 (attack) and attack duration × 16 in its low twelve bits. The new level is visible on the clock after the strobe.
- R2: A tick decrements the counter by one while the phase is nonzero and the low twelve bits are nonzero. Without a tick (and without a start), neither the counter nor the amplitude changes.
- R3: A tick that finds the phase nonzero and the low twelve bits at zero changes the phase instead of decrementing. Each phase therefore lasts duration × 16 + 1 ticks.
- R4: Leaving attack forces the amplitude to 0 and loads phase 2 (gap) with gap duration × 16.
- R5: Leaving the gap sets the amplitude to the sustain amplitude and loads phase 1 (sustain) with sustain duration × 16.
- R6: Leaving sustain, or finishing a release interval, replaces the amplitude with floor(amplitude × 3 / 4) and reloads the counter with 0x1FFF. Release steps are therefore 4096 ticks apart, and 15 falls as 11, 8, 6, 4, 3, 2, 1, 0.
- R7: The output level equals the amplitude while the noise input is 1, and is 0 while it is 0.
- R8: After reset, the amplitude and the counter are zero, so the output is 0 for any noise value.
- R9: A release step that yields amplitude 0 clears the counter to phase 0, and the level stays 0 on all later ticks until the next start.
- R10: A start strobe wins over a tick in the same cycle, and a start during any phase restarts the full attack at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Envelope update enable, one step per high cycle |
| noise | input | 1 | Noise bit that gates the output |
| start | input | 1 | Envelope start strobe |
| atkAmp | input | 4 | Attack amplitude |
| susAmp | input | 4 | Sustain amplitude |
| atkDur | input | 8 | Attack duration in units of 16 ticks |
| gapDur | input | 8 | Gap duration in units of 16 ticks |
| susDur | input | 8 | Sustain duration in units of 16 ticks |
| level | output | 4 | Gated output level |

## Verification
The only visible state is the amplitude, so a wrong counter shows up as a level step that comes too early or too late. The bench therefore samples one tick before and one tick after every expected phase boundary. An extra or missing decrement moves a boundary by exactly one tick and is caught at once. A wrong release factor or a wrong reload shows at the first release step, which comes 4096 ticks after the previous one. A counter that fails to clear after the final release would show as nonzero level, or as a restart that does not take.

// File: rtl/nenv_pkg.sv
package nenv_pkg;

  localparam int PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_DONE = 2'd0,
    PH_SUS  = 2'd1,
    PH_GAP  = 2'd2,
    PH_ATK  = 2'd3
  } phase_e;

  // one action per clock, selected by the control
  typedef struct packed {
    logic loadAttack;
    logic enterGap;
    logic enterSustain;
    logic releaseStep;
    logic countDown;
  } envStrobe_t;

endpackage

// File: rtl/nenv_ctrl.sv
module nenv_ctrl
  import nenv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       tick,
  input  phase_e     phase,
  input  logic       lowZero,
  output envStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (start) begin
      strobe.loadAttack = 1'b1;
    end else if (tick && phase != PH_DONE) begin
      if (lowZero) begin
        unique case (phase)
          PH_ATK:  strobe.enterGap     = 1'b1;
          PH_GAP:  strobe.enterSustain = 1'b1;
          default: strobe.releaseStep  = 1'b1;
        endcase
      end else begin
        strobe.countDown = 1'b1;
      end
    end
  end

  // R3: a single action per cycle, never a count at a phase edge
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R10: start always produces the attack load, whatever the tick does
  a_r10_start_wins: assert property (@(posedge clk) disable iff (!rstN)
    (start && tick) |-> !strobe.countDown && !strobe.releaseStep);

  // R2: no tick and no start means no action
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !tick) |-> strobe == '0);

endmodule

// File: rtl/nenv_datapath.sv
module nenv_datapath
  import nenv_pkg::*;
#(
  parameter int AMP_W = 4,
  parameter int DUR_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  envStrobe_t       strobe,
  input  logic [AMP_W-1:0] atkAmp,
  input  logic [AMP_W-1:0] susAmp,
  input  logic [DUR_W-1:0] atkDur,
  input  logic [DUR_W-1:0] gapDur,
  input  logic [DUR_W-1:0] susDur,
  output phase_e           phase,
  output logic             lowZero,
  output logic [AMP_W-1:0] amp
);

  localparam int LOW_W = DUR_W + PRE_W;
  localparam int CNT_W = PHASE_W + LOW_W;
  localparam int MUL_W = AMP_W + 2;

  logic [CNT_W-1:0] cntQ, cntD;
  logic [AMP_W-1:0] ampQ, ampD;
  logic [MUL_W-1:0] scaled;
  logic [AMP_W-1:0] shrunk;

  assign phase   = phase_e'(cntQ[CNT_W-1 -: PHASE_W]);
  assign lowZero = (cntQ[LOW_W-1:0] == '0);
  assign amp     = ampQ;

  // three quarters with truncation
  assign scaled = MUL_W'(ampQ) + (MUL_W'(ampQ) << 1);
  assign shrunk = scaled[MUL_W-1:2];

  always_comb begin
    cntD = cntQ;
    ampD = ampQ;
    if (strobe.loadAttack) begin
      cntD = {PH_ATK, atkDur, {PRE_W{1'b0}}};
      ampD = atkAmp;
    end else if (strobe.enterGap) begin
      cntD = {PH_GAP, gapDur, {PRE_W{1'b0}}};
      ampD = '0;
    end else if (strobe.enterSustain) begin
      cntD = {PH_SUS, susDur, {PRE_W{1'b0}}};
      ampD = susAmp;
    end else if (strobe.releaseStep) begin
      ampD = shrunk;
      cntD = (shrunk == '0) ? '0 : {PH_SUS, {LOW_W{1'b1}}};
    end else if (strobe.countDown) begin
      cntD = cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      ampQ <= '0;
    end else begin
      cntQ <= cntD;
      ampQ <= ampD;
    end
  end

  // R1: a start lands the attack amplitude and the attack phase
  a_r1_start_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAttack |=> (ampQ == $past(atkAmp)) && (phase == PH_ATK));

  // R2: with no action the state holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(cntQ) && $stable(ampQ));

  // R4: the gap is always silent
  a_r4_gap_silent: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_GAP) |-> (ampQ == '0));

  // R6: a release step never raises the level nor leaves sustain/done
  a_r6_release_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    strobe.releaseStep |=> (ampQ <= $past(ampQ)) && (phase != PH_ATK) && (phase != PH_GAP));

  // R9: a finished envelope is silent
  a_r9_done_silent: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |-> (ampQ == '0));

endmodule

// File: rtl/noise_env_channel.sv
module noise_env_channel
  import nenv_pkg::*;
#(
  parameter int AMP_W = 4,
  parameter int DUR_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             noise,
  input  logic             start,
  input  logic [AMP_W-1:0] atkAmp,
  input  logic [AMP_W-1:0] susAmp,
  input  logic [DUR_W-1:0] atkDur,
  input  logic [DUR_W-1:0] gapDur,
  input  logic [DUR_W-1:0] susDur,
  output logic [AMP_W-1:0] level
);

  envStrobe_t       strobe;
  phase_e           phase;
  logic             lowZero;
  logic [AMP_W-1:0] amp;

  nenv_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .tick   (tick),
    .phase  (phase),
    .lowZero(lowZero),
    .strobe (strobe)
  );

  nenv_datapath #(
    .AMP_W(AMP_W),
    .DUR_W(DUR_W),
    .PRE_W(PRE_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .atkAmp (atkAmp),
    .susAmp (susAmp),
    .atkDur (atkDur),
    .gapDur (gapDur),
    .susDur (susDur),
    .phase  (phase),
    .lowZero(lowZero),
    .amp    (amp)
  );

  // per-bit noise gating
  for (genvar i = 0; i < AMP_W; i++) begin : g_gate
    assign level[i] = amp[i] & noise;
  end

  // R7: silent whenever noise is low
  a_r7_gate: assert property (@(posedge clk) disable iff (!rstN)
    !noise |-> (level == '0));

endmodule

// File: tb/noise_env_channel_bench.sv
module noise_env_channel_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       noise = 1'b1;
  logic       start = 1'b0;
  logic [3:0] atkAmp = '0, susAmp = '0;
  logic [7:0] atkDur = '0, gapDur = '0, susDur = '0;
  logic [3:0] level;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  noise_env_channel u_noise_env_channel (
    .clk(clk), .rstN(rstN), .tick(tick), .noise(noise), .start(start),
    .atkAmp(atkAmp), .susAmp(susAmp), .atkDur(atkDur), .gapDur(gapDur),
    .susDur(susDur), .level(level)
  );

  // {atkAmp, susAmp, atkDur, gapDur, susDur}
  localparam logic [31:0] VEC [5] = '{
    {4'd9,  4'd5,  8'd2, 8'd1, 8'd3},
    {4'd15, 4'd15, 8'd0, 8'd0, 8'd0},
    {4'd4,  4'd0,  8'd1, 8'd0, 8'd1},
    {4'd0,  4'd7,  8'd3, 8'd2, 8'd0},
    {4'd12, 4'd10, 8'd1, 8'd3, 8'd2}
  };

  task automatic check(string req, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: level got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic runTicks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic setParams(logic [31:0] v);
    {atkAmp, susAmp, atkDur, gapDur, susDur} = v;
  endtask

  function automatic int threeQuarter(int x);
    return (x * 3) / 4;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got running expected finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset", level, 0);
    rstN = 1'b1;
    @(negedge clk);
    runTicks(20);
    check("R8 idle after reset", level, 0);

    // table walk: each start also restarts the previous envelope (R10)
    for (int v = 0; v < 5; v++) begin
      int a, s, d, g, u;
      setParams(VEC[v]);
      a = VEC[v][31:28]; s = VEC[v][27:24];
      d = VEC[v][23:16]; g = VEC[v][15:8]; u = VEC[v][7:0];
      pulseStart();
      check("R1 attack level", level, a);
      runTicks(d * 16);
      check("R2 attack held", level, a);
      runTicks(1);
      check("R3/R4 gap entered", level, 0);
      runTicks(g * 16);
      check("R4 gap held", level, 0);
      runTicks(1);
      check("R5 sustain entered", level, s);
      runTicks(u * 16);
      check("R5 sustain held", level, s);
      runTicks(1);
      check("R6 first release", level, threeQuarter(s));
    end

    // R7: gating by noise
    setParams({4'd6, 4'd3, 8'd1, 8'd2, 8'd0});
    pulseStart();
    noise = 1'b0;
    #1;
    check("R7 noise low", level, 0);
    noise = 1'b1;
    #1;
    check("R7 noise high", level, 6);

    // R2: idle cycles without tick do not advance
    runTicks(10);
    repeat (100) @(negedge clk);
    runTicks(6);
    check("R2 no tick no count", level, 6);
    runTicks(1);
    check("R2 attack ends on time", level, 0);

    // R10: restart from the gap
    runTicks(5);
    pulseStart();
    check("R10 restart level", level, 6);
    runTicks(16);
    check("R10 full attack again", level, 6);
    runTicks(1);
    check("R10 attack end", level, 0);

    // R10: start together with tick does not decrement
    setParams({4'd11, 4'd2, 8'd2, 8'd0, 8'd0});
    start = 1'b1; tick = 1'b1;
    @(negedge clk);
    start = 1'b0; tick = 1'b0;
    check("R10 start beats tick", level, 11);
    runTicks(32);
    check("R10 attack length kept", level, 11);
    runTicks(1);
    check("R10 attack end", level, 0);

    // R6 and R9: complete release from 15
    setParams({4'd15, 4'd15, 8'd0, 8'd0, 8'd0});
    pulseStart();
    runTicks(2);
    check("R5 sustain 15", level, 15);
    runTicks(1);
    check("R6 release 11", level, 11);
    begin
      int cur;
      cur = 11;
      while (cur != 0) begin
        runTicks(4095);
        check("R6 release interval", level, cur);
        runTicks(1);
        cur = threeQuarter(cur);
        check("R6 release step", level, cur);
      end
    end
    runTicks(5000);
    check("R9 stopped at zero", level, 0);
    pulseStart();
    check("R9 restart after done", level, 15);

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule